// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the control logic of a byte-wide flash array. It watches each host write (an address plus a data byte) and recognises the multi-write command sequences that unlock and start flash operations. Every sequence starts with the same two-write unlock prefix. The third write selects the command, and the longer commands add further writes after it. When a sequence completes, the block issues a one-cycle request that carries the captured target address and data. It also keeps two flags: one for identification mode and one for the permanent boot-sector lockout.

While the execution engine reports that an operation is in progress, the block ignores host writes and holds its progress. A write that does not fit the current step of a sequence sends the decoder back to idle. Such a write never produces a request.

In identification mode, the host reads fixed codes through a small offset port. One of those codes reports the lockout state. Once the lockout is active, a program request aimed at the boot sector is refused and flagged. A chip erase request carries a flag telling the engine to keep the boot sector intact.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After reset, no request or refusal pulse is high, and `id_mode` and `boot_locked` are 0.
- R2: Unlock and command addresses are compared on address bits 14:0 only. Bits 16:15 are ignored, so 0x15555 counts as 0x5555 and 0x12AAA counts as 0x2AAA.
- R3: A byte program is the following writes: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, then one write to any address. In the cycle after that last write, `prog_req` is high, `op_addr` holds the last write's address and `op_data` holds its data.
- R4: A chip erase is the following writes: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555. In the cycle after the sixth write, `erase_req` is high and `erase_keep_boot` equals `boot_locked`.
- R5: The boot lockout uses the same six writes as the chip erase except that the last one is 40@5555. In the cycle after that write, `boot_locked` becomes 1. After that it stays 1 until reset, and this sequence issues no request.
- R6: The writes AA@5555, 55@2AAA, 90@5555 set `id_mode`. Two things clear it: the writes AA@5555, 55@2AAA, F0@5555, or a single write of 0xF0 to any address made while the decoder is idle.
- R7: `id_data` depends on `id_offset`. Offset 0 gives 0x1F, offset 1 gives 0x17, offset 2 gives 0x00 with `boot_locked` in bit 0, and offset 3 gives 0x00.
- R8: A write whose address or data does not match the current step returns the decoder to idle without any request. A following full sequence then works normally.
- R9: While `boot_locked` is 1, the final program write to an address below 0x02000 gives a one-cycle `prog_denied` pulse and no `prog_req`. An address of 0x02000 or above is forwarded normally.
- R10: While `busy` is 1, writes are ignored. The sequence position, both flags and all outputs behave as if no write happened.
- R11: `prog_req`, `erase_req` and `prog_denied` are each high for one cycle only, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 17 | Host write address |
| wr_data | input | 8 | Host write data |
| busy | input | 1 | Execution engine busy; writes are ignored while high |
| id_offset | input | 2 | Identification read offset |
| prog_req | output | 1 | One-cycle byte program request |
| erase_req | output | 1 | One-cycle chip erase request |
| erase_keep_boot | output | 1 | With erase_req: the boot sector must be kept |
| prog_denied | output | 1 | One-cycle pulse: program into the locked boot sector was refused |
| op_addr | output | 17 | Target address of the program request |
| op_data | output | 8 | Data byte of the program request |
| id_mode | output | 1 | Identification mode active |
| boot_locked | output | 1 | Boot-sector lockout active |
| id_data | output | 8 | Identification code at id_offset |

## Verification
The hardest situation to reach from the ports is the one where the third, command-selecting write takes an unexpected value. Every byte value there has its own outcome. The bench therefore sweeps all 256 data values through that step. It follows each one with a candidate target write and computes the expected request and mode flag from the value itself. The locked-boot refusal is reached only after a complete lockout sequence. The bench then probes the addresses on both sides of the sector boundary. It also places `busy` writes between the steps of a live sequence, to show that those writes do not disturb its progress.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3
    } seq_st_e;
endpackage

// File: rtl/cmd_key_match.sv
module cmd_key_match #(
    parameter int          KEY_W  = 15,
    parameter logic [14:0] KEY_LO = 15'h5555,
    parameter logic [14:0] KEY_HI = 15'h2AAA
) (
    input  logic [KEY_W-1:0] key_addr,
    input  logic [7:0]       key_data,
    output logic             at_lo,
    output logic             at_hi,
    output logic             d_aa,
    output logic             d_55,
    output logic             d_a0,
    output logic             d_80,
    output logic             d_90,
    output logic             d_f0,
    output logic             d_10,
    output logic             d_40
);
    always_comb begin
        at_lo = (key_addr == KEY_LO[KEY_W-1:0]);
        at_hi = (key_addr == KEY_HI[KEY_W-1:0]);
        d_aa  = (key_data == 8'hAA);
        d_55  = (key_data == 8'h55);
        d_a0  = (key_data == 8'hA0);
        d_80  = (key_data == 8'h80);
        d_90  = (key_data == 8'h90);
        d_f0  = (key_data == 8'hF0);
        d_10  = (key_data == 8'h10);
        d_40  = (key_data == 8'h40);
    end
endmodule

// File: rtl/cmd_id_rom.sv
module cmd_id_rom #(
    parameter logic [7:0] MFR_CODE = 8'h1F,
    parameter logic [7:0] DEV_CODE = 8'h17
) (
    input  logic [1:0] rom_off,
    input  logic       rom_locked,
    output logic [7:0] rom_data
);
    always_comb begin
        unique case (rom_off)
            2'd0:    rom_data = MFR_CODE;
            2'd1:    rom_data = DEV_CODE;
            2'd2:    rom_data = {7'd0, rom_locked};
            default: rom_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
    import cmd_seq_pkg::*;
#(
    parameter int                 ADDR_W   = 17,
    parameter int                 KEY_W    = 15,
    parameter logic [ADDR_W-1:0]  BOOT_END = 17'h02000,
    parameter logic [7:0]         MFR_CODE = 8'h1F,
    parameter logic [7:0]         DEV_CODE = 8'h17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic [1:0]        id_offset,
    output logic              prog_req,
    output logic              erase_req,
    output logic              erase_keep_boot,
    output logic              prog_denied,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              id_mode,
    output logic              boot_locked,
    output logic [7:0]        id_data
);
    typedef struct packed {
        seq_st_e           st;
        logic              idm;
        logic              lock;
        logic              preq;
        logic              ereq;
        logic              keep;
        logic              deny;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } dec_regs_t;

    dec_regs_t r_d, r_q;

    logic at_lo, at_hi, d_aa, d_55, d_a0, d_80, d_90, d_f0, d_10, d_40;
    logic take;
    logic in_boot;

    cmd_key_match #(.KEY_W(KEY_W)) u_match (
        .key_addr (wr_addr[KEY_W-1:0]),
        .key_data (wr_data),
        .at_lo    (at_lo),
        .at_hi    (at_hi),
        .d_aa     (d_aa),
        .d_55     (d_55),
        .d_a0     (d_a0),
        .d_80     (d_80),
        .d_90     (d_90),
        .d_f0     (d_f0),
        .d_10     (d_10),
        .d_40     (d_40)
    );

    cmd_id_rom #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rom (
        .rom_off    (id_offset),
        .rom_locked (r_q.lock),
        .rom_data   (id_data)
    );

    assign take    = wr_en && !busy;
    assign in_boot = (wr_addr < BOOT_END);

    always_comb begin
        r_d      = r_q;
        r_d.preq = 1'b0;
        r_d.ereq = 1'b0;
        r_d.deny = 1'b0;
        r_d.keep = 1'b0;
        if (take) begin
            r_d.st = ST_IDLE;
            unique case (r_q.st)
                ST_IDLE: begin
                    if (at_lo && d_aa) r_d.st  = ST_UNL1;
                    else if (d_f0)     r_d.idm = 1'b0;
                end
                ST_UNL1: if (at_hi && d_55) r_d.st = ST_UNL2;
                ST_UNL2: begin
                    if (at_lo) begin
                        if (d_a0)      r_d.st  = ST_PROG;
                        else if (d_80) r_d.st  = ST_ERS1;
                        else if (d_90) r_d.idm = 1'b1;
                        else if (d_f0) r_d.idm = 1'b0;
                    end
                end
                ST_PROG: begin
                    if (r_q.lock && in_boot) begin
                        r_d.deny = 1'b1;
                    end else begin
                        r_d.preq = 1'b1;
                        r_d.addr = wr_addr;
                        r_d.data = wr_data;
                    end
                end
                ST_ERS1: if (at_lo && d_aa) r_d.st = ST_ERS2;
                ST_ERS2: if (at_hi && d_55) r_d.st = ST_ERS3;
                ST_ERS3: begin
                    if (at_lo && d_10) begin
                        r_d.ereq = 1'b1;
                        r_d.keep = r_q.lock;
                    end else if (at_lo && d_40) begin
                        r_d.lock = 1'b1;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, data: '0, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_req        = r_q.preq;
    assign erase_req       = r_q.ereq;
    assign erase_keep_boot = r_q.keep;
    assign prog_denied     = r_q.deny;
    assign op_addr         = r_q.addr;
    assign op_data         = r_q.data;
    assign id_mode         = r_q.idm;
    assign boot_locked     = r_q.lock;

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req, prog_denied}));

    // R11
    preq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

    // R9
    boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !(boot_locked && (op_addr < BOOT_END)));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(r_q.st) && $stable(id_mode) && !prog_req && !erase_req && !prog_denied));

    // R4
    keep_follows_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (erase_keep_boot == boot_locked));

    // R7
    always_comb begin
        if (rst_n && id_offset == 2'd2) begin
            id_lock_bit_chk: assert (id_data == {7'd0, boot_locked});
        end
    end
endmodule

// File: tb/cmd_seq_decoder_bench.sv
module cmd_seq_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic [1:0]  id_offset = '0;
    logic        prog_req, erase_req, erase_keep_boot, prog_denied;
    logic [16:0] op_addr;
    logic [7:0]  op_data;
    logic        id_mode, boot_locked;
    logic [7:0]  id_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cmd_seq_decoder u_cmd_seq_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .id_offset(id_offset),
        .prog_req(prog_req), .erase_req(erase_req),
        .erase_keep_boot(erase_keep_boot), .prog_denied(prog_denied),
        .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode),
        .boot_locked(boot_locked), .id_data(id_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unl();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    task automatic pulses(input string tag, input logic p, input logic e, input logic dn);
        chk({tag, " prog_req"}, prog_req, p);
        chk({tag, " erase_req"}, erase_req, e);
        chk({tag, " prog_denied"}, prog_denied, dn);
    endtask

    task automatic id_sweep(input string tag, input logic lk);
        for (int o = 0; o < 4; o++) begin
            logic [7:0] exp;
            id_offset = o[1:0];
            #1;
            exp = (o == 0) ? 8'h1F : (o == 1) ? 8'h17 : (o == 2) ? {7'd0, lk} : 8'h00;
            chk(tag, id_data, exp);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        pulses("R1", 0, 0, 0);
        chk("R1 id_mode", id_mode, 0);
        chk("R1 boot_locked", boot_locked, 0);

        // R3 basic program, R11 single-cycle pulse
        unl(); wr(17'h05555, 8'hA0); wr(17'h1ABCD, 8'h3C);
        pulses("R3", 1, 0, 0);
        chk("R3 op_addr", op_addr, 17'h1ABCD);
        chk("R3 op_data", op_data, 8'h3C);
        @(negedge clk);
        chk("R11 prog_req drops", prog_req, 0);

        // R8 / R3 / R6 sweep of the command byte
        for (int d = 0; d < 256; d++) begin
            logic exp_idm;
            exp_idm = id_mode;
            if (d == 8'h90) exp_idm = 1'b1;
            if (d == 8'hF0) exp_idm = 1'b0;
            unl(); wr(17'h05555, d[7:0]);
            chk("R6 sweep id_mode", id_mode, exp_idm);
            wr(17'h03000, 8'h5A);
            chk("R8 sweep prog_req", prog_req, d == 8'hA0);
            if (d == 8'hA0) chk("R3 sweep op_data", op_data, 8'h5A);
        end
        wr(17'h00000, 8'hF0);

        // R2 upper address bits ignored
        wr(17'h15555, 8'hAA); wr(17'h12AAA, 8'h55); wr(17'h1D555, 8'hA0); wr(17'h04000, 8'h11);
        pulses("R2 high bits", 1, 0, 0);
        wr(17'h05554, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(17'h04000, 8'h11);
        pulses("R2 low bit differs", 0, 0, 0);

        // R8 wrong address in step 2, then a clean sequence
        wr(17'h05555, 8'hAA); wr(17'h02AAB, 8'h55); wr(17'h05555, 8'hA0); wr(17'h04000, 8'h22);
        pulses("R8 bad addr", 0, 0, 0);
        unl(); wr(17'h05555, 8'hA0); wr(17'h04001, 8'h22);
        pulses("R8 recovery", 1, 0, 0);

        // R6 entry and both exits, R7 codes unlocked
        unl(); wr(17'h05555, 8'h90);
        chk("R6 entry", id_mode, 1);
        id_sweep("R7 unlocked", 1'b0);
        wr(17'h01234, 8'hF0);
        chk("R6 single F0 exit", id_mode, 0);
        unl(); wr(17'h05555, 8'h90);
        unl(); wr(17'h05555, 8'hF0);
        chk("R6 three-write exit", id_mode, 0);

        // R4 erase unlocked; R8 erase aborted at last step
        unl(); wr(17'h05555, 8'h80); unl(); wr(17'h05555, 8'h10);
        pulses("R4 erase", 0, 1, 0);
        chk("R4 keep_boot", erase_keep_boot, 0);
        unl(); wr(17'h05555, 8'h80); unl(); wr(17'h05555, 8'h20);
        pulses("R8 erase abort", 0, 0, 0);
        chk("R8 no lock", boot_locked, 0);

        // R10 busy writes ignored mid-sequence
        wr(17'h05555, 8'hAA);
        busy = 1'b1; wr(17'h05555, 8'h00); busy = 1'b0;
        wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
        busy = 1'b1; wr(17'h06000, 8'h77);
        pulses("R10 busy target", 0, 0, 0);
        wr(17'h00000, 8'hF0);
        busy = 1'b0;
        wr(17'h06000, 8'h78);
        pulses("R10 after busy", 1, 0, 0);
        chk("R10 op_data", op_data, 8'h78);

        // R5 lockout
        unl(); wr(17'h05555, 8'h80); unl(); wr(17'h05555, 8'h40);
        pulses("R5 lock", 0, 0, 0);
        chk("R5 boot_locked", boot_locked, 1);
        id_sweep("R7 locked", 1'b1);

        // R9 boundary
        unl(); wr(17'h05555, 8'hA0); wr(17'h01FFF, 8'h01);
        pulses("R9 1FFF", 0, 0, 1);
        unl(); wr(17'h05555, 8'hA0); wr(17'h00000, 8'h02);
        pulses("R9 0000", 0, 0, 1);
        unl(); wr(17'h05555, 8'hA0); wr(17'h02000, 8'h03);
        pulses("R9 2000", 1, 0, 0);
        chk("R9 op_addr", op_addr, 17'h02000);
        unl(); wr(17'h05555, 8'hA0); wr(17'h1FFFF, 8'h04);
        pulses("R9 1FFFF", 1, 0, 0);

        // R4 erase when locked
        unl(); wr(17'h05555, 8'h80); unl(); wr(17'h05555, 8'h10);
        pulses("R4 locked erase", 0, 1, 0);
        chk("R4 keep_boot locked", erase_keep_boot, 1);

        // R5 persistence
        unl(); wr(17'h05555, 8'h90); unl(); wr(17'h05555, 8'hF0);
        wr(17'h00002, 8'hF0);
        repeat (5) @(negedge clk);
        chk("R5 persists", boot_locked, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule